// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory DMA Engine

This block moves data between memory locations on behalf of four independent channels. Each channel is set up through a small register port. Its settings are a source address, a destination address, a 24-bit unit count and a 16-bit control word. The control word chooses three things: the size of each unit, how each address steps after a unit, and what starts the channel. A channel can start on its own, or it can move one unit for each pulse on its request line.

A single shared engine performs each unit as a read request at the source address followed by a write request at the destination address. The write carries the data returned by the read. After the write completes, the engine writes the stepped addresses and the decremented count back into the channel's registers. When the count reaches zero, the channel's transfer-end flag is set. An interrupt line is raised when that flag and the channel's interrupt-enable bit are both set. A global mode register must hold the enable pattern before any channel runs. When several channels are ready, the lowest-numbered channel is served first.

Top module: `dma4_core`

## Requirements
- R1: After reset, every channel's control word, address and count read as zero, the global mode register reads zero, and `irq`, `addr_err` and `mem_req` are low.
- R2: Channel n occupies `reg_addr` 16*n: offset 0 source, 4 destination, 8 count (bits 23:0 only, upper bits read 0), 12 control (bits 15:0 only). The global mode register sits at address 0x40 and reads back all 32 bits.
- R3: No unit starts unless bits 2:0 of the global mode register equal 3'b001.
- R4: A channel is active only when control bits 1:0 equal 2'b01 (bit 0 enable, bit 1 transfer-end). With request code (control bits 11:8) 4, 5 or 6, an active channel runs by itself. With any other code, it performs exactly one unit per pulse on its `dreq` bit.
- R5: Control bits 6:4 select the unit size given on `mem_bytes`: 0 gives 8, 1 gives 1, 2 gives 2, 3 gives 4, 4 gives 32, and 5 to 7 give 1.
- R6: Control bits 13:12 (source) and 15:14 (destination) step the address after each unit: 0 keeps it, 1 adds the unit size, 2 subtracts it.
- R7: An active channel with step code 3 in either field drives its `addr_err` bit high and performs no unit.
- R8: Each unit lowers the count by one. A programmed count of 0 stands for 2^24 units, so one unit leaves 0xFFFFFF with transfer-end still clear.
- R9: The unit that brings the count to zero sets control bit 1, and the channel then stops.
- R10: `irq[n]` is high exactly while control bit 1 and bit 2 (interrupt enable) of channel n are both set. A control write that leaves either bit clear drops it.
- R11: Only one unit is in flight at a time, and among ready channels the lowest index is served first.
- R12: Each unit issues a read (`mem_we`=0) at the source, then a write (`mem_we`=1) at the destination carrying the read data. Each request holds its address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 4 | Per-channel unit request pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_bytes | output | 6 | Bytes in this unit |
| mem_wdata | output | 256 | Write data |
| mem_rdata | input | 256 | Read data |
| mem_ack | input | 1 | Request accepted / read data valid |
| irq | output | 4 | Per-channel interrupt |
| addr_err | output | 4 | Per-channel illegal step-mode flag |

## Verification
The engine is exercised with a self-starting channel that steps both addresses upward, and with a channel that steps its source down while its destination stays fixed under a slow acknowledge. A sweep over all eight size codes, with opposite step directions, tells the size table apart from the step logic. Request-driven channels with a single pulse, with a set transfer-end flag, and with a zero count separate one-unit-per-pulse operation from the stop condition and from the 2^24 encoding. A mixed load of three ready channels shows that service order follows priority and is not interleaved.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int NCH    = 4;
  localparam int CHW    = $clog2(NCH);
  localparam int AW     = 32;
  localparam int CNT_W  = 24;
  localparam int CTL_W  = 16;
  localparam int MAXB   = 32;
  localparam int BW     = $clog2(MAXB) + 1;
  localparam int DATA_W = MAXB * 8;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_UP   = 2'd1,
    AM_DOWN = 2'd2,
    AM_BAD  = 2'd3
  } amode_e;

  typedef struct packed {
    logic [CHW-1:0] ch;
    logic [AW-1:0]  src;
    logic [AW-1:0]  dst;
    logic [BW-1:0]  bytes;
    amode_e         sm;
    amode_e         dm;
  } unit_t;

  function automatic logic [BW-1:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return BW'(8);
      3'd2:    return BW'(2);
      3'd3:    return BW'(4);
      3'd4:    return BW'(32);
      default: return BW'(1);
    endcase
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input amode_e m,
                                              input logic [BW-1:0] b);
    case (m)
      AM_UP:   return a + AW'(b);
      AM_DOWN: return a - AW'(b);
      default: return a;
    endcase
  endfunction

  function automatic logic self_start(input logic [3:0] code);
    return (code >= 4'd4) && (code <= 4'd6);
  endfunction
endpackage

// File: rtl/dmx_chan.sv
module dmx_chan import dmx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_off,
  input  logic [31:0]      wr_data,
  input  logic             upd,
  input  logic [AW-1:0]    upd_src,
  input  logic [AW-1:0]    upd_dst,
  input  logic             dreq,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             ready_o,
  output logic             irq_o,
  output logic             aerr_o
);
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CTL_W-1:0] ctl_q;
  logic             pend_q;
  logic             active, last_unit;

  assign active    = (ctl_q[1:0] == 2'b01);
  assign last_unit = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (upd) begin
        src_q  <= upd_src;
        dst_q  <= upd_dst;
        cnt_q  <= cnt_q - CNT_W'(1);
        pend_q <= 1'b0;
        if (last_unit) ctl_q[1] <= 1'b1;
      end
      if (dreq) pend_q <= 1'b1;
      if (wr_en) begin
        case (wr_off)
          2'd0: src_q <= wr_data;
          2'd1: dst_q <= wr_data;
          2'd2: cnt_q <= wr_data[CNT_W-1:0];
          default: ctl_q <= wr_data[CTL_W-1:0];
        endcase
      end
    end
  end

  assign aerr_o  = active && ((ctl_q[13:12] == 2'd3) || (ctl_q[15:14] == 2'd3));
  assign ready_o = active && !aerr_o && (self_start(ctl_q[11:8]) || pend_q);
  assign irq_o   = ctl_q[2] && ctl_q[1];
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign ctl_o   = ctl_q;

  assert_te_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && last_unit && !wr_en) |=> ctl_q[1]);
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == 2'd3 && !(wr_data[2] && wr_data[1])) |=> !irq_o);
endmodule

// File: rtl/dmx_arb.sv
module dmx_arb #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmx_xfer.sv
module dmx_xfer import dmx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  unit_t             start_unit,
  output logic              idle,
  output logic              done,
  output logic [CHW-1:0]    done_ch,
  output logic [AW-1:0]     nxt_src,
  output logic [AW-1:0]     nxt_dst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BW-1:0]     mem_bytes,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_UPD} st_e;
  st_e               st_q;
  unit_t             u_q;
  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      u_q   <= '0;
      buf_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          u_q  <= start_unit;
          st_q <= S_RD;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st_q  <= S_WR;
        end
        S_WR:    if (mem_ack) st_q <= S_UPD;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == S_IDLE);
  assign done      = (st_q == S_UPD);
  assign done_ch   = u_q.ch;
  assign nxt_src   = step_addr(u_q.src, u_q.sm, u_q.bytes);
  assign nxt_dst   = step_addr(u_q.dst, u_q.dm, u_q.bytes);
  assign mem_req   = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = (st_q == S_WR) ? u_q.dst : u_q.src;
  assign mem_bytes = u_q.bytes;
  assign mem_wdata = buf_q;

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_wr_follows_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));
  assert_single_unit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !idle) |-> 1'b0);
endmodule

// File: rtl/dma4_core.sv
module dma4_core import dmx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    dreq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BW-1:0]     mem_bytes,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    addr_err
);
  logic [AW-1:0]    src_w [NCH];
  logic [AW-1:0]    dst_w [NCH];
  logic [CNT_W-1:0] cnt_w [NCH];
  logic [CTL_W-1:0] ctl_w [NCH];
  logic [NCH-1:0]   ready, grant;
  logic [CHW-1:0]   gidx, done_ch, rsel;
  logic             any_ready, eng_idle, done, start, master_en;
  logic [AW-1:0]    nxt_src, nxt_dst;
  logic [31:0]      master_q;
  unit_t            pick;

  always_ff @(posedge clk) begin
    if (!rst_n)                       master_q <= '0;
    else if (reg_we && reg_addr[6])   master_q <= reg_wdata;
  end
  assign master_en = (master_q[2:0] == 3'b001);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_hit;
    assign wr_hit = reg_we && !reg_addr[6] && (reg_addr[5:4] == CHW'(i));
    dmx_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hit),
      .wr_off  (reg_addr[3:2]),
      .wr_data (reg_wdata),
      .upd     (done && (done_ch == CHW'(i))),
      .upd_src (nxt_src),
      .upd_dst (nxt_dst),
      .dreq    (dreq[i]),
      .src_o   (src_w[i]),
      .dst_o   (dst_w[i]),
      .cnt_o   (cnt_w[i]),
      .ctl_o   (ctl_w[i]),
      .ready_o (ready[i]),
      .irq_o   (irq[i]),
      .aerr_o  (addr_err[i])
    );
  end

  dmx_arb #(.N(NCH)) u_arb (
    .req (ready),
    .gnt (grant),
    .idx (gidx),
    .any (any_ready)
  );

  assign start = eng_idle && master_en && any_ready;

  always_comb begin
    pick.ch    = gidx;
    pick.src   = src_w[gidx];
    pick.dst   = dst_w[gidx];
    pick.bytes = unit_bytes(ctl_w[gidx][6:4]);
    pick.sm    = amode_e'(ctl_w[gidx][13:12]);
    pick.dm    = amode_e'(ctl_w[gidx][15:14]);
  end

  dmx_xfer u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_unit (pick),
    .idle       (eng_idle),
    .done       (done),
    .done_ch    (done_ch),
    .nxt_src    (nxt_src),
    .nxt_dst    (nxt_dst),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_bytes  (mem_bytes),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack)
  );

  assign rsel = reg_addr[5:4];
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[6]) reg_rdata = master_q;
    else begin
      case (reg_addr[3:2])
        2'd0:    reg_rdata = src_w[rsel];
        2'd1:    reg_rdata = dst_w[rsel];
        2'd2:    reg_rdata = {{(32-CNT_W){1'b0}}, cnt_w[rsel]};
        default: reg_rdata = {{(32-CTL_W){1'b0}}, ctl_w[rsel]};
      endcase
    end
  end

  assert_master_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we) |-> $past(master_en));
  assert_no_bad_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !addr_err[gidx]);
  assert_grant_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_ready == (grant != '0)));
endmodule

// File: tb/dma4_core_test.sv
`timescale 1ns/1ps
module dma4_core_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [6:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   dreq = '0;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [5:0]   mem_bytes;
  logic [255:0] mem_wdata, mem_rdata;
  logic         mem_ack = 1'b0;
  logic [3:0]   irq, addr_err;

  int checks = 0, errors = 0, ack_lat = 0, wcnt = 0, nlog = 0, base = 0;
  logic [31:0] la [256];
  logic        lw [256];
  logic [5:0]  lb [256];
  logic [31:0] ld [256];

  always #2.5 clk = ~clk;

  dma4_core uut (.*);

  assign mem_rdata = {8{mem_addr ^ 32'hA5A5_0000}};

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= ack_lat) begin mem_ack <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else mem_ack <= 1'b0;
  end

  always @(negedge clk) begin
    if (mem_req && mem_ack && nlog < 256) begin
      la[nlog] = mem_addr; lw[nlog] = mem_we; lb[nlog] = mem_bytes;
      ld[nlog] = mem_wdata[31:0]; nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] c, input logic [31:0] ctl);
    wr(7'(ch*16), s); wr(7'(ch*16+4), d); wr(7'(ch*16+8), c); wr(7'(ch*16+12), ctl);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); dreq[ch] = 1'b1; @(negedge clk); dreq = '0;
  endtask

  task automatic wait_units(input int n);
    int t = 0;
    while (nlog < base + 2*n && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [5:0] exp_bytes(input int code);
    case (code) 0: return 8; 2: return 2; 3: return 4; 4: return 32; default: return 1; endcase
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 4; o++) begin rd(7'(c*16+o*4), v); chk(v == 0, "R1 reg zero", v, 0); end
    end
    rd(7'h40, v); chk(v == 0, "R1 mode zero", v, 0);
    chk({irq, addr_err, mem_req} == 0, "R1 outputs low", {irq, addr_err, 3'b0, mem_req}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    setup(2, 32'h1111_0000, 32'h2222_0004, 32'hAB12_3456, 32'hFFFF_0030);
    rd(7'h20, v); chk(v == 32'h1111_0000, "R2 src", v, 32'h1111_0000);
    rd(7'h24, v); chk(v == 32'h2222_0004, "R2 dst", v, 32'h2222_0004);
    rd(7'h28, v); chk(v == 32'h0012_3456, "R2 count 24b", v, 32'h0012_3456);
    rd(7'h2C, v); chk(v == 32'h0000_0030, "R2 ctl 16b", v, 32'h30);
    wr(7'h40, 32'hDEAD_BEE8); rd(7'h40, v); chk(v == 32'hDEAD_BEE8, "R2 mode reg", v, 32'hDEAD_BEE8);
    wr(7'h40, 0); wr(7'h2C, 0);
  endtask

  task automatic t_master;
    logic [31:0] v;
    base = nlog;
    wr(7'h40, 32'h3);
    setup(0, 32'h1000, 32'h2000, 2, 32'h5431);
    repeat (40) @(negedge clk);
    chk(nlog == base, "R3 mode 011 blocks", nlog - base, 0);
    wr(7'h40, 32'h1);
    wait_units(2);
    chk(nlog - base == 4, "R4 self start two units", nlog - base, 4);
    chk(la[base] == 32'h1000 && !lw[base], "R12 read at src", la[base], 32'h1000);
    chk(la[base+1] == 32'h2000 && lw[base+1], "R12 write at dst", la[base+1], 32'h2000);
    chk(ld[base+1] == (32'h1000 ^ 32'hA5A5_0000), "R12 write carries read data", ld[base+1], 32'h1000 ^ 32'hA5A5_0000);
    chk(la[base+2] == 32'h1004 && la[base+3] == 32'h2004, "R6 increment both", la[base+2], 32'h1004);
    chk(lb[base] == 4, "R5 size code 3", 32'(lb[base]), 4);
    rd(7'h00, v); chk(v == 32'h1008, "R6 src readback", v, 32'h1008);
    rd(7'h08, v); chk(v == 0, "R8 count zero", v, 0);
    rd(7'h0C, v); chk(v == 32'h5433, "R9 transfer-end set", v, 32'h5433);
    repeat (30) @(negedge clk);
    chk(nlog - base == 4, "R9 stopped", nlog - base, 4);
    wr(7'h0C, 0);
  endtask

  task automatic t_modes;
    logic [31:0] v;
    base = nlog; ack_lat = 3;
    setup(1, 32'h8000, 32'h9000, 2, 32'h2541);
    wait_units(2);
    chk(la[base] == 32'h8000 && la[base+2] == 32'h7FE0, "R6 source decrement", la[base+2], 32'h7FE0);
    chk(la[base+1] == 32'h9000 && la[base+3] == 32'h9000, "R6 destination fixed", la[base+3], 32'h9000);
    chk(lb[base] == 32, "R5 size code 4", 32'(lb[base]), 32);
    rd(7'h10, v); chk(v == 32'h7FC0, "R6 src after dec", v, 32'h7FC0);
    ack_lat = 0; wr(7'h1C, 0);
    for (int code = 0; code < 8; code++) begin
      base = nlog;
      setup(2, 32'h4000, 32'h6000, 1, 32'h9401 | 32'(code << 4));
      wait_units(1);
      chk(lb[base] == exp_bytes(code), "R5 size table", 32'(lb[base]), 32'(exp_bytes(code)));
      rd(7'h20, v); chk(v == 32'h4000 + 32'(exp_bytes(code)), "R6 src inc by size", v, 32'h4000 + 32'(exp_bytes(code)));
      rd(7'h24, v); chk(v == 32'h6000 - 32'(exp_bytes(code)), "R6 dst dec by size", v, 32'h6000 - 32'(exp_bytes(code)));
    end
    wr(7'h2C, 0);
  endtask

  task automatic t_dreq;
    logic [31:0] v;
    base = nlog;
    setup(2, 32'hA000, 32'hB000, 3, 32'h5231);
    repeat (20) @(negedge clk);
    chk(nlog == base, "R4 code 2 waits for request", nlog - base, 0);
    pulse(2); wait_units(1); repeat (20) @(negedge clk);
    chk(nlog - base == 2, "R4 one unit per pulse", nlog - base, 2);
    rd(7'h28, v); chk(v == 2, "R8 count step", v, 2);
    base = nlog;
    wr(7'h2C, 32'h5233); pulse(2); repeat (30) @(negedge clk);
    chk(nlog == base, "R4 transfer-end blocks", nlog - base, 0);
    rd(7'h28, v); chk(v == 2, "R4 count untouched", v, 2);
    wr(7'h2C, 0);
    base = nlog;
    setup(3, 32'hC000, 32'hD000, 0, 32'h0331);
    pulse(3); wait_units(1);
    rd(7'h38, v); chk(v == 32'hFF_FFFF, "R8 zero count is 2^24", v, 32'hFF_FFFF);
    rd(7'h3C, v); chk(v == 32'h0331, "R8 no transfer-end", v, 32'h0331);
    wr(7'h3C, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    base = nlog;
    setup(0, 32'h100, 32'h200, 1, 32'h5435);
    wait_units(1);
    chk(irq == 4'b0001, "R10 irq on end", 32'(irq), 1);
    wr(7'h0C, 32'h5432); chk(irq == 0, "R10 irq off ie clear", 32'(irq), 0);
    wr(7'h0C, 32'h0004); chk(irq == 0, "R10 irq off te clear", 32'(irq), 0);
    wr(7'h0C, 32'h0006); chk(irq == 4'b0001, "R10 irq both set", 32'(irq), 1);
    wr(7'h0C, 0); chk(irq == 0, "R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_err;
    logic [31:0] v;
    base = nlog;
    setup(1, 32'h300, 32'h400, 1, 32'h3431);
    repeat (40) @(negedge clk);
    chk(addr_err == 4'b0010, "R7 src mode 3 flag", 32'(addr_err), 2);
    chk(nlog == base, "R7 no unit", nlog - base, 0);
    wr(7'h1C, 32'hC431); repeat (40) @(negedge clk);
    chk(addr_err == 4'b0010 && nlog == base, "R7 dst mode 3", 32'(addr_err), 2);
    rd(7'h18, v); chk(v == 1, "R7 count kept", v, 1);
    wr(7'h1C, 0); chk(addr_err == 0, "R7 flag cleared", 32'(addr_err), 0);
  endtask

  task automatic t_prio;
    logic [31:0] exp [5] = '{32'h100, 32'h104, 32'h500, 32'h504, 32'h900};
    wr(7'h40, 0);
    base = nlog;
    setup(1, 32'h500, 32'h600, 2, 32'h5431);
    setup(0, 32'h100, 32'h200, 2, 32'h5431);
    setup(2, 32'h900, 32'hA00, 1, 32'h5231);
    pulse(2);
    wr(7'h40, 1);
    wait_units(5);
    chk(nlog - base == 10, "R11 total units", nlog - base, 10);
    for (int k = 0; k < 5; k++)
      chk(la[base+2*k] == exp[k] && !lw[base+2*k] && lw[base+2*k+1], "R11 priority order", la[base+2*k], exp[k]);
    wr(7'h0C, 0); wr(7'h1C, 0); wr(7'h2C, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_master;
    t_modes;
    t_dreq;
    t_irq;
    t_err;
    t_prio;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule